// File: doc/BRIEF.md
# Write Status Read Multiplexer

This block decides what a read on the parallel data bus returns while a memory write is under way. A write starts with a load phase, in which bytes are latched and a load window timer runs. An internally timed programming phase follows. Whenever either phase is active, a qualified read does not return array contents. It returns three status bits instead, and the remaining data lines are left undriven. When no write is active, the array byte passes straight through on all lines.

The three status bits each give the host its own way to detect completion. The top bit is the complement of the top bit of the last latched byte. The next bit alternates on every read, and its first read in each write cycle is 0. The third bit reports whether the load window is still open. The block produces the read value together with a per-bit drive-enable mask, which the pad ring uses to control the output buffers. Write capture and array storage sit elsewhere.

Top module: `write_status_reporter`

## Requirements
- R1: After reset, no data line is driven while no read is qualified, and the first read of the first write cycle returns 0 on the toggle bit (bit 6).
- R2: A read is qualified only when `chip_en_n` and `out_en_n` are 0 and `wr_en_n` is 1. Otherwise `drv_en` is all zeros and `rd_data` is all zeros.
- R3: A qualified read with `load_active` and `busy` both 0 returns `array_data` on `rd_data`, with `drv_en` all ones.
- R4: A qualified read with `load_active` or `busy` at 1 drives only bits 7, 6 and 5 (`drv_en` = 8'hE0). Bits 4 to 0 of `rd_data` are 0.
- R5: In status mode, bit 7 of `rd_data` is the complement of bit 7 of `last_byte`.
- R6: In status mode, bit 6 starts at 0 and inverts after each qualified read that ends while the write is still active. A read ends on the first clock edge at which the read is no longer qualified.
- R7: In status mode, bit 5 of `rd_data` equals `load_active`: 1 while the load window is open, 0 once it has closed.
- R8: The toggle bit returns to 0 at the start of every new write cycle. A write cycle starts on the first clock edge at which `load_active` or `busy` is seen at 1 after both were 0.
- R9: When the write completes during a held read, `rd_data` switches to `array_data` on all lines in the same cycle. A read that ends after completion does not change the toggle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_en_n | input | 1 | Chip enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| wr_en_n | input | 1 | Write enable, active low |
| load_active | input | 1 | Load window timer running |
| busy | input | 1 | Internal programming in progress |
| last_byte | input | 8 | Most recently latched write byte |
| array_data | input | 8 | Array read data for the current address |
| rd_data | output | 8 | Value presented for the read |
| drv_en | output | 8 | Per-bit output driver enable |

## Verification
The assertions assume that `load_active`, `busy` and the three strobes are synchronous to `clk` and stable around its rising edge. They also assume that `last_byte` holds its value for as long as status is reported. The bench drives every input on the falling edge and changes the write flags only between reads. It waits one edge after each flag change, so a write start and a read end never fall on the same edge. Random values are used for the array byte, the last byte, the strobe combination and the flag state. Directed cases cover the first read after reset, a toggle restart and completion during a held read.

// File: rtl/wsr_pkg.sv
// Package: shared constants for the write status reporter.
// Assumes the data width is at least three bits, so that three status bits fit.
package wsr_pkg;
    // Status bits counted down from the top of the data word
    localparam int POLL_OFS  = 1;
    localparam int TGL_OFS   = 2;
    localparam int TIMER_OFS = 3;

    // Phase of the write seen by the read path
    typedef enum logic [1:0] {
        PH_IDLE   = 2'b00,
        PH_LOAD   = 2'b01,
        PH_PROG   = 2'b10,
        PH_LDPROG = 2'b11
    } wr_phase_e;
endpackage

// File: rtl/wsr_strobe.sv
// Module: wsr_strobe
// Qualifies the read strobes, marks the edge at which a read ends and
// the edge at which a write cycle starts.
// Assumes all inputs are synchronous to clk.
module wsr_strobe
    import wsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chip_en_n,
    input  logic out_en_n,
    input  logic wr_en_n,
    input  logic load_active,
    input  logic busy,
    output logic rd_now,
    output logic rd_end,
    output logic wr_act,
    output logic wr_start
);
    logic      rd_q;
    logic      wr_q;
    wr_phase_e phase;

    // Classify the current write phase from the controller flags
    always_comb begin
        phase = wr_phase_e'({busy, load_active});
    end

    // Decode the qualified read and the two edge events
    always_comb begin
        rd_now   = !chip_en_n && !out_en_n && wr_en_n;
        wr_act   = (phase != PH_IDLE);
        rd_end   = rd_q && !rd_now;
        wr_start = wr_act && !wr_q;
    end

    // Remember last cycle's read and write activity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
            wr_q <= 1'b0;
        end else begin
            rd_q <= rd_now;
            wr_q <= wr_act;
        end
    end

    // R2: a qualified read excludes write enable low
    p_rd_excl_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_now |-> wr_en_n);

    // R8: a start event cannot repeat on consecutive edges
    p_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> !wr_start);
endmodule

// File: rtl/wsr_toggle.sv
// Module: wsr_toggle
// Holds the alternating status bit. It clears at each write start and
// inverts when a read ends during an active write.
// Assumes the wr_start and rd_end events come from wsr_strobe.
module wsr_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_act,
    input  logic wr_start,
    input  logic rd_end,
    output logic tgl
);
    // Update the toggle; a write start takes priority over a read end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgl <= 1'b0;
        end else if (wr_start) begin
            tgl <= 1'b0;
        end else if (rd_end && wr_act) begin
            tgl <= !tgl;
        end
    end

    // R8: a new write cycle restarts the toggle at zero
    p_tgl_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> (tgl == 1'b0));

    // R6: a read ending inside a write flips the bit
    p_tgl_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_end && wr_act && !wr_start) |=> (tgl != $past(tgl)));

    // R9: without a read end or a start, the bit holds
    p_tgl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_start && !(rd_end && wr_act)) |=> $stable(tgl));
endmodule

// File: rtl/wsr_outmux.sv
// Module: wsr_outmux
// Builds the read value and the per-bit drive mask from either the array
// data or the three status bits.
// Assumes last_byte is stable while status is reported.
module wsr_outmux
    import wsr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_now,
    input  logic          wr_act,
    input  logic          load_active,
    input  logic          tgl,
    input  logic [DW-1:0] last_byte,
    input  logic [DW-1:0] array_data,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] drv_en
);
    localparam int POLL_B  = DW - POLL_OFS;
    localparam int TGL_B   = DW - TGL_OFS;
    localparam int TIMER_B = DW - TIMER_OFS;

    logic [DW-1:0] stat_val;
    logic [DW-1:0] stat_drv;

    // Lay out the status word bit by bit
    for (genvar i = 0; i < DW; i++) begin : g_stat
        if (i == POLL_B) begin : g_poll
            assign stat_val[i] = !last_byte[POLL_B];
            assign stat_drv[i] = 1'b1;
        end else if (i == TGL_B) begin : g_tgl
            assign stat_val[i] = tgl;
            assign stat_drv[i] = 1'b1;
        end else if (i == TIMER_B) begin : g_timer
            assign stat_val[i] = load_active;
            assign stat_drv[i] = 1'b1;
        end else begin : g_float
            assign stat_val[i] = 1'b0;
            assign stat_drv[i] = 1'b0;
        end
    end

    // Choose between idle bus, status word and array data
    always_comb begin
        if (!rd_now) begin
            rd_data = '0;
            drv_en  = '0;
        end else if (wr_act) begin
            rd_data = stat_val;
            drv_en  = stat_drv;
        end else begin
            rd_data = array_data;
            drv_en  = '1;
        end
    end

    // R2: nothing is driven without a qualified read
    p_no_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_now |-> (drv_en == '0));

    // R4: the undriven status lines stay low
    p_float_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_now && wr_act) |-> (drv_en[TIMER_B-1:0] == '0 && rd_data[TIMER_B-1:0] == '0));

    // R5: the polling bit inverts the last latched top bit
    p_poll_inv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_now && wr_act) |-> (rd_data[POLL_B] != last_byte[POLL_B]));

    // R3: an idle read drives every line with array data
    p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_now && !wr_act) |-> (drv_en == '1 && rd_data == array_data));
endmodule

// File: rtl/write_status_reporter.sv
// Module: write_status_reporter
// Top level of the read path during writes: array data when idle, and
// polling, toggle and load-timer bits while a write is active.
// Assumes the controller flags and strobes are synchronous to clk.
module write_status_reporter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chip_en_n,
    input  logic          out_en_n,
    input  logic          wr_en_n,
    input  logic          load_active,
    input  logic          busy,
    input  logic [DW-1:0] last_byte,
    input  logic [DW-1:0] array_data,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] drv_en
);
    logic rd_now;
    logic rd_end;
    logic wr_act;
    logic wr_start;
    logic tgl;

    wsr_strobe u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_en_n  (chip_en_n),
        .out_en_n   (out_en_n),
        .wr_en_n    (wr_en_n),
        .load_active(load_active),
        .busy       (busy),
        .rd_now     (rd_now),
        .rd_end     (rd_end),
        .wr_act     (wr_act),
        .wr_start   (wr_start)
    );

    wsr_toggle u_toggle (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_act  (wr_act),
        .wr_start(wr_start),
        .rd_end  (rd_end),
        .tgl     (tgl)
    );

    wsr_outmux #(.DW(DW)) u_outmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_now     (rd_now),
        .wr_act     (wr_act),
        .load_active(load_active),
        .tgl        (tgl),
        .last_byte  (last_byte),
        .array_data (array_data),
        .rd_data    (rd_data),
        .drv_en     (drv_en)
    );

    // R7: the timer bit follows the load flag during status reads
    p_timer_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en_n && !out_en_n && wr_en_n && (load_active || busy))
            |-> (rd_data[DW-3] == load_active));
endmodule

// File: tb/tb_write_status_reporter.sv
module tb_write_status_reporter;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       chip_en_n, out_en_n, wr_en_n;
    logic       load_active, busy;
    logic [7:0] last_byte, array_data;
    logic [7:0] rd_data, drv_en;

    int checks = 0;
    int errors = 0;
    logic tgl_m;     // model of the toggle bit
    logic act_m;     // model of write activity

    always #(CLK_PERIOD/2) clk = ~clk;

    write_status_reporter dut (
        .clk(clk), .rst_n(rst_n),
        .chip_en_n(chip_en_n), .out_en_n(out_en_n), .wr_en_n(wr_en_n),
        .load_active(load_active), .busy(busy),
        .last_byte(last_byte), .array_data(array_data),
        .rd_data(rd_data), .drv_en(drv_en)
    );

    // Expected {rd_data, drv_en} from the requirements
    function automatic logic [15:0] expect_out(input logic qual, input logic ld,
                                               input logic bz, input logic [7:0] lb,
                                               input logic [7:0] arr, input logic t);
        if (!qual) return 16'h0000;
        if (ld || bz) return {~lb[7], t, ld, 5'b0, 8'hE0};
        return {arr, 8'hFF};
    endfunction

    task automatic check(input string req, input logic [15:0] exp);
        checks++;
        if ({rd_data, drv_en} !== exp) begin
            errors++;
            $display("FAIL %s: got data=%h drv=%h, expected data=%h drv=%h",
                     req, rd_data, drv_en, exp[15:8], exp[7:0]);
        end
    endtask

    // Set write flags at a falling edge, then let one rising edge pass
    task automatic set_flags(input logic ld, input logic bz);
        @(negedge clk);
        if (!act_m && (ld || bz)) tgl_m = 1'b0;
        act_m = ld || bz;
        load_active = ld;
        busy = bz;
        @(negedge clk);
    endtask

    // One access with the given strobes; checks while held, then releases
    task automatic access(input logic ce, input logic oe, input logic we, input string req);
        logic qual;
        @(negedge clk);
        chip_en_n = ce; out_en_n = oe; wr_en_n = we;
        qual = !ce && !oe && we;
        #1;
        check(req, expect_out(qual, load_active, busy, last_byte, array_data, tgl_m));
        @(negedge clk);
        chip_en_n = 1'b1; out_en_n = 1'b1; wr_en_n = 1'b1;
        if (qual && act_m) tgl_m = !tgl_m;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        chip_en_n = 1'b1; out_en_n = 1'b1; wr_en_n = 1'b1;
        load_active = 1'b0; busy = 1'b0;
        last_byte = 8'h00; array_data = 8'h00;
        tgl_m = 1'b0; act_m = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset idle", 16'h0000);

        // R3: idle pass-through
        array_data = 8'h5A;
        access(1'b0, 1'b0, 1'b1, "R3 idle read");
        // R2: write enable low disqualifies
        access(1'b0, 1'b0, 1'b0, "R2 we low");
        access(1'b1, 1'b0, 1'b1, "R2 ce high");

        // R1/R6/R7: first write cycle, load phase
        last_byte = 8'h80;
        set_flags(1'b1, 1'b0);
        access(1'b0, 1'b0, 1'b1, "R1 first toggle read");
        access(1'b0, 1'b0, 1'b1, "R6 second toggle read");
        access(1'b0, 1'b1, 1'b1, "R2 oe high during write");
        access(1'b0, 1'b0, 1'b1, "R6 third toggle read");
        // R7: load window closed, programming continues
        set_flags(1'b0, 1'b1);
        last_byte = 8'h00;
        access(1'b0, 1'b0, 1'b1, "R7 timer expired R5 poll");

        // R9: complete during a held read
        @(negedge clk);
        array_data = 8'hC3;
        chip_en_n = 1'b0; out_en_n = 1'b0; wr_en_n = 1'b1;
        #1;
        check("R4 held status read", expect_out(1'b1, 1'b0, 1'b1, last_byte, array_data, tgl_m));
        @(negedge clk);
        busy = 1'b0; act_m = 1'b0;
        #1;
        check("R9 completion switches to array", {8'hC3, 8'hFF});
        @(negedge clk);
        chip_en_n = 1'b1; out_en_n = 1'b1;
        @(negedge clk);

        // R8: new write cycle restarts toggle
        set_flags(1'b1, 1'b1);
        access(1'b0, 1'b0, 1'b1, "R8 restart first read");

        // Random mix
        for (int i = 0; i < 300; i++) begin
            logic [1:0] st;
            logic [2:0] sb;
            st = 2'($urandom_range(0, 3));
            if (st != {busy, load_active}) set_flags(st[0], st[1]);
            last_byte = 8'($urandom);
            array_data = 8'($urandom);
            sb = 3'($urandom_range(0, 7));
            if (sb < 3'd5) access(1'b0, 1'b0, 1'b1, "R6 random read");
            else access(sb[0], sb[1], !sb[2], "R2 random strobe");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule